// File: doc/BRIEF.md
# Sampled FIFO Slot Conformance Checker

This block is a synthesizable monitor placed beside a circular-buffer FIFO of capacity N. It watches the FIFO's write-side and read-side ready/valid handshakes and the occupancy value the FIFO reports. It does not hold a copy of the whole queue. It picks one slot of the circular buffer and looks only at the writes and reads that land on that slot, which is one transfer in every N on each side. It checks that this thinned stream behaves like a one-entry FIFO, using a single holding register.

Alongside the slot check, the monitor keeps its own occupancy count and its own write and read positions. It compares the count with the reported value on every cycle. It also checks that the state of its holding register agrees with the number of reads still due before the chosen slot comes out. Every distinct violation sets its own sticky bit in `err_flags`. Only reset clears these bits. The slot to watch is taken from `slot_sel` while reset is asserted.

Top module: `fifo_slot_monitor`

## Requirements
- R1: An internal occupancy count, reset to 0, rises by one when only the write handshake (valid and ready) fires and falls by one when only the read handshake fires. An increment attempted at N instead sets err_flags[0] and leaves the count at N. A decrement attempted at 0 instead sets err_flags[1] and leaves the count at 0.
- R2: Whenever the internal occupancy count differs from `fifo_count`, err_flags[2] is set.
- R3: A write position and a read position, both reset to 0, advance by one on their own handshake. Each wraps from N-1 back to 0 and never reaches N.
- R4: A write is sampled only when the write position equals the captured slot. A read is sampled only when the read position equals the captured slot.
- R5: With the holding register empty, a sampled write alone loads its data into the register. A sampled write and a sampled read in the same cycle leave the register empty, and if the two data words differ they set err_flags[4].
- R6: With the holding register empty, a sampled read without a same-cycle sampled write sets err_flags[3].
- R7: With the holding register full, a sampled write without a same-cycle sampled read sets err_flags[6] and leaves the register unchanged.
- R8: With the holding register full, a sampled read whose data differs from the held word sets err_flags[5]. After any sampled read the register holds the same-cycle sampled write's data if there is one, and is empty otherwise.
- R9: The reads pending before the slot is read are (slot - read position) when slot >= read position, and (slot + N - read position) otherwise. The holding register must be full exactly when this value is below the internal occupancy count, else err_flags[7] is set (only for an in-range slot).
- R10: The slot is captured from `slot_sel` on clock edges while reset is high, and later changes of `slot_sel` have no effect. A captured slot of N or more sets err_flags[8].
- R11: Each err_flags bit is set on the clock edge that ends the cycle in which its violation is present, stays set, and is cleared only by synchronous active-high reset. Reset also zeroes the counters and empties the holding register.
- R12: Traffic from a correct FIFO, including full, empty, refused and simultaneous transfers and position wrap-around, sets no err_flags bit for any in-range slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the slot |
| slot_sel | input | IDXW | Slot of the circular buffer to watch |
| in_valid | input | 1 | Write-side valid of the observed FIFO |
| in_ready | input | 1 | Write-side ready of the observed FIFO |
| in_data | input | DW | Write-side data |
| out_valid | input | 1 | Read-side valid of the observed FIFO |
| out_ready | input | 1 | Read-side ready of the observed FIFO |
| out_data | input | DW | Read-side data |
| fifo_count | input | CNTW | Occupancy reported by the observed FIFO |
| err_flags | output | 9 | Sticky violation bits, indexed as in the requirements |

## Verification
The bench watches slots 0, N/2 and N-1 while a reference FIFO runs through fills past capacity, drains past empty and simultaneous transfers. A monitor that wrapped its positions at the wrong point, or ran its counter past N, would raise false flags there. Directed cases cover a write and a read on the slot in the same cycle with an empty holding register. A monitor that loaded the register in that case would later report a spurious read or an accept-while-full. The bench also makes a slot hit on both sides while the register is full and checks that the new word is carried forward; a monitor that emptied the register would flag the next slot read as spurious. Further cases cover saturation at both ends of the count, an occupancy check built from a position that has gone out of step, an out-of-range slot, and a change of `slot_sel` after reset, which must not change which transfers are sampled.

// File: rtl/fifo_mon_pkg.sv
package fifo_mon_pkg;

  localparam int unsigned ERR_OVERFLOW  = 0;
  localparam int unsigned ERR_UNDERFLOW = 1;
  localparam int unsigned ERR_COUNT     = 2;
  localparam int unsigned ERR_SPURIOUS  = 3;
  localparam int unsigned ERR_PASS_DATA = 4;
  localparam int unsigned ERR_HELD_DATA = 5;
  localparam int unsigned ERR_ACCEPT    = 6;
  localparam int unsigned ERR_OCCUPY    = 7;
  localparam int unsigned ERR_SLOT      = 8;
  localparam int unsigned NUM_ERR       = 9;

  // Next position on a ring of `depth` entries.
  function automatic int unsigned ring_next(int unsigned pos, int unsigned depth);
    return (pos == depth - 1) ? 0 : pos + 1;
  endfunction

  // Reads still due before `slot` is read, given the current read position.
  function automatic int unsigned reads_until_slot(int unsigned slot, int unsigned rd,
                                                   int unsigned depth);
    return (slot >= rd) ? (slot - rd) : (slot + depth - rd);
  endfunction

endpackage

// File: rtl/mon_position.sv
module mon_position #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  output logic [IDXW-1:0] pos
);
  import fifo_mon_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (fire) pos <= IDXW'(ring_next(32'(pos), DEPTH));
  end
endmodule

// File: rtl/mon_occupancy.sv
module mon_occupancy #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned CNTW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic [CNTW-1:0] count,
  output logic            ev_over,
  output logic            ev_under
);
  logic at_full, at_empty;

  assign at_full  = (count == CNTW'(DEPTH));
  assign at_empty = (count == '0);
  assign ev_over  = push && !pop && at_full;
  assign ev_under = pop && !push && at_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (push && !pop && !at_full) begin
      count <= count + CNTW'(1);
    end else if (pop && !push && !at_empty) begin
      count <= count - CNTW'(1);
    end
  end
endmodule

// File: rtl/mon_holding.sv
module mon_holding #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_in,
  input  logic          s_out,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] out_data,
  output logic          full,
  output logic          ev_spurious,
  output logic          ev_pass_data,
  output logic          ev_held_data,
  output logic          ev_accept
);
  logic [DW-1:0] held;

  assign ev_spurious  = !full && s_out && !s_in;
  assign ev_pass_data = !full && s_out && s_in && (out_data != in_data);
  assign ev_held_data = full && s_out && (out_data != held);
  assign ev_accept    = full && s_in && !s_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      held <= '0;
    end else if (!full) begin
      if (s_in && !s_out) begin
        full <= 1'b1;
        held <= in_data;
      end
    end else if (s_out) begin
      full <= s_in;
      if (s_in) held <= in_data;
    end
  end
endmodule

// File: rtl/fifo_slot_monitor.sv
module fifo_slot_monitor
  import fifo_mon_pkg::*;
#(
  parameter  int unsigned DEPTH = 5,
  parameter  int unsigned DW    = 8,
  localparam int unsigned CNTW  = $clog2(DEPTH + 1),
  localparam int unsigned IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDXW-1:0]    slot_sel,
  input  logic               in_valid,
  input  logic               in_ready,
  input  logic [DW-1:0]      in_data,
  input  logic               out_valid,
  input  logic               out_ready,
  input  logic [DW-1:0]      out_data,
  input  logic [CNTW-1:0]    fifo_count,
  output logic [NUM_ERR-1:0] err_flags
);

  logic [IDXW-1:0] slot_q;
  logic            slot_ok;
  logic            wr_fire, rd_fire;
  logic            samp_in, samp_out;
  logic [IDXW-1:0] wr_pos, rd_pos;
  logic [CNTW-1:0] occ_count;
  logic [CNTW-1:0] pend_reads;
  logic            hold_full;
  logic [NUM_ERR-1:0] err_event;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= slot_sel;
  end

  assign slot_ok  = (32'(slot_q) < DEPTH);
  assign wr_fire  = in_valid && in_ready;
  assign rd_fire  = out_valid && out_ready;
  assign samp_in  = wr_fire && (wr_pos == slot_q);
  assign samp_out = rd_fire && (rd_pos == slot_q);

  mon_position #(.DEPTH(DEPTH), .IDXW(IDXW)) u_wr_pos (
    .clk(clk), .rst(rst), .fire(wr_fire), .pos(wr_pos)
  );

  mon_position #(.DEPTH(DEPTH), .IDXW(IDXW)) u_rd_pos (
    .clk(clk), .rst(rst), .fire(rd_fire), .pos(rd_pos)
  );

  mon_occupancy #(.DEPTH(DEPTH), .CNTW(CNTW)) u_occ (
    .clk      (clk),
    .rst      (rst),
    .push     (wr_fire),
    .pop      (rd_fire),
    .count    (occ_count),
    .ev_over  (err_event[ERR_OVERFLOW]),
    .ev_under (err_event[ERR_UNDERFLOW])
  );

  mon_holding #(.DW(DW)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .s_in         (samp_in),
    .s_out        (samp_out),
    .in_data      (in_data),
    .out_data     (out_data),
    .full         (hold_full),
    .ev_spurious  (err_event[ERR_SPURIOUS]),
    .ev_pass_data (err_event[ERR_PASS_DATA]),
    .ev_held_data (err_event[ERR_HELD_DATA]),
    .ev_accept    (err_event[ERR_ACCEPT])
  );

  assign pend_reads = CNTW'(reads_until_slot(32'(slot_q), 32'(rd_pos), DEPTH));

  assign err_event[ERR_COUNT]  = (occ_count != fifo_count);
  assign err_event[ERR_OCCUPY] = slot_ok && (hold_full != (pend_reads < occ_count));
  assign err_event[ERR_SLOT]   = !slot_ok;

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)               err_flags[g] <= 1'b0;
      else if (err_event[g]) err_flags[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/fifo_slot_monitor_checks.sv
module fifo_slot_monitor_checks
  import fifo_mon_pkg::*;
#(
  parameter  int unsigned DEPTH = 5,
  parameter  int unsigned DW    = 8,
  localparam int unsigned CNTW  = $clog2(DEPTH + 1),
  localparam int unsigned IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [CNTW-1:0]    occ_count,
  input logic [CNTW-1:0]    fifo_count,
  input logic [IDXW-1:0]    wr_pos,
  input logic [IDXW-1:0]    rd_pos,
  input logic               samp_in,
  input logic               samp_out,
  input logic               hold_full,
  input logic [NUM_ERR-1:0] err_event,
  input logic [NUM_ERR-1:0] err_flags
);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    32'(occ_count) <= DEPTH);

  assert_overflow_flag_R1: assert property (@(posedge clk) disable iff (rst)
    err_event[ERR_OVERFLOW] |=> err_flags[ERR_OVERFLOW]);

  assert_count_compare_R2: assert property (@(posedge clk) disable iff (rst)
    (occ_count != fifo_count) |=> err_flags[ERR_COUNT]);

  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(wr_pos) < DEPTH) && (32'(rd_pos) < DEPTH));

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (samp_in && !samp_out && !hold_full) |=> hold_full);

  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (samp_out && !samp_in && hold_full) |=> !hold_full);

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_sticky_chk
    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
      err_flags[g] |=> err_flags[g]);
  end

endmodule

bind fifo_slot_monitor fifo_slot_monitor_checks #(.DEPTH(DEPTH), .DW(DW)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .occ_count  (occ_count),
  .fifo_count (fifo_count),
  .wr_pos     (wr_pos),
  .rd_pos     (rd_pos),
  .samp_in    (samp_in),
  .samp_out   (samp_out),
  .hold_full  (hold_full),
  .err_event  (err_event),
  .err_flags  (err_flags)
);

// File: tb/fifo_slot_monitor_test.sv
module fifo_slot_monitor_test;

  localparam int N  = 5;
  localparam int IW = 3;
  localparam int CW = 3;

  // Traffic table: {write request, read request}. Expected result of every
  // step with a correct FIFO underneath: err_flags == 0 (R12).
  localparam logic [1:0] PAT [24] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b11, 2'b11, 2'b11, 2'b11,
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b11, 2'b11, 2'b01, 2'b10, 2'b10,
    2'b11, 2'b11, 2'b11
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] slot_sel = '0;
  logic          in_valid = 1'b0, in_ready = 1'b0;
  logic [7:0]    in_data = '0;
  logic          out_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]    out_data = '0;
  logic [CW-1:0] fifo_count = '0;
  logic [8:0]    err_flags;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mq [N];
  int         mw, mr, mc;
  logic [7:0] dseq;

  always #2 clk = ~clk;

  fifo_slot_monitor #(.DEPTH(N), .DW(8)) uut (
    .clk(clk), .rst(rst), .slot_sel(slot_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_count(fifo_count), .err_flags(err_flags)
  );

  task automatic chk(input string req, input logic [8:0] exp);
    checks++;
    if (err_flags !== exp) begin
      fails++;
      $display("FAIL %s: err_flags=%h expected %h", req, err_flags, exp);
    end
  endtask

  // Drive one cycle; returns at the negedge after the capturing posedge.
  task automatic cyc(input logic iv, input logic ir, input logic [7:0] id,
                     input logic ov, input logic orr, input logic [7:0] od,
                     input int cnt);
    in_valid = iv; in_ready = ir; in_data = id;
    out_valid = ov; out_ready = orr; out_data = od;
    fifo_count = CW'(cnt);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [IW-1:0] s);
    rst = 1'b1;
    slot_sel = s;
    in_valid = 1'b0; in_ready = 1'b0; out_valid = 1'b0; out_ready = 1'b0;
    fifo_count = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_traffic(input logic [IW-1:0] s);
    logic fi, fo;
    do_reset(s);
    mw = 0; mr = 0; mc = 0; dseq = 8'h40;
    for (int rep = 0; rep < 2; rep++) begin
      for (int i = 0; i < 24; i++) begin
        fi = PAT[i][1] && (mc < N);
        fo = PAT[i][0] && (mc > 0);
        cyc(PAT[i][1], mc < N, dseq, mc > 0, PAT[i][0], mq[mr], mc);
        if (fo) mr = (mr + 1) % N;
        if (fi) begin
          mq[mw] = dseq;
          mw = (mw + 1) % N;
          dseq = dseq + 8'd1;
        end
        mc = mc + int'(fi) - int'(fo);
        chk("R12", 9'h000);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    do_reset(3'd0);
    chk("R11", 9'h000);

    // R12 / R3 / R4: correct traffic for several slots, with wrap-around
    run_traffic(3'd0);
    run_traffic(3'd2);
    run_traffic(3'd4);

    // R1 + R7: sixth write at N overflows and hits the full holding register
    do_reset(3'd0);
    for (int k = 0; k < 5; k++) cyc(1, 1, 8'(k + 1), 0, 0, 0, k);
    chk("R1", 9'h000);
    cyc(1, 1, 8'h06, 0, 0, 0, 5);
    chk("R7", 9'h041);
    // R11: flags stay set
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 5);
    chk("R11", 9'h041);
    do_reset(3'd0);
    chk("R11", 9'h000);

    // R1: read at zero occupancy on a slot not hit
    do_reset(3'd1);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R1", 9'h002);

    // R2: reported count differs
    do_reset(3'd0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R2", 9'h000);
    cyc(0, 0, 0, 0, 0, 0, 3);
    chk("R2", 9'h004);

    // R6: sampled read with empty holding register (also underflow)
    do_reset(3'd0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R6", 9'h00A);

    // R5: simultaneous sampled write and read while empty
    do_reset(3'd0);
    cyc(1, 1, 8'h11, 1, 1, 8'h11, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R5", 9'h000);
    do_reset(3'd0);
    cyc(1, 1, 8'h11, 1, 1, 8'h22, 0);
    chk("R5", 9'h010);

    // R8: held word compared on the slot read
    do_reset(3'd0);
    cyc(1, 1, 8'hA5, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'hA5, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8", 9'h000);
    do_reset(3'd0);
    cyc(1, 1, 8'hA5, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'h5A, 1);
    chk("R8", 9'h020);

    // R8: full register, slot hit on both sides reloads the new word
    do_reset(3'd0);
    for (int k = 0; k < 5; k++) cyc(1, 1, (k == 0) ? 8'hD1 : 8'(k), 0, 0, 0, k);
    cyc(1, 1, 8'h77, 1, 1, 8'hD1, 5);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1, 8'h00, 5 - k);
    cyc(0, 0, 0, 1, 1, 8'h77, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8", 9'h000);

    // R9: read position skewed by an underflow, then a slot write
    do_reset(3'd0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R9", 9'h00A);
    cyc(1, 1, 8'h33, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R9", 9'h08A);

    // R10: out-of-range slot
    do_reset(3'd6);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R10", 9'h100);

    // R10: slot_sel change after reset is ignored; slot 0 still sampled
    do_reset(3'd0);
    slot_sel = 3'd6;
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R10", 9'h000);
    slot_sel = 3'd3;
    cyc(1, 1, 8'hAA, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 8'hBB, 1);
    chk("R10", 9'h020);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule